// File: doc/BRIEF.md
# Coin Credit Ledger

This block keeps the credit balance of a coin-operated machine as two BCD digits, from 00 to 99. It does its work once per frame, on a one-cycle `frame_tick` strobe. On each strobe it samples the active-low coin, service, start and test levels and the operating mode supplied by the surrounding logic. It then applies one frame's worth of accounting. Between strobes the balance and all pulse outputs stay quiet.

Each coin slot has its own coins-per-credit and credits-per-coin setting. It also has a private partial-coin counter, so fractional credit carries over until a whole credit is earned. Coin, service and start inputs are qualified by a short per-frame history, so a bouncing or one-frame contact never counts. An accepted coin emits a one-cycle event for an external meter driver. A start in the idle mode spends credits and raises a request that the mode owner uses to enter the active mode. A test input outside the init mode wipes the balance and asks the mode owner to return to init.

Every pin is a plain per-frame level or a one-cycle pulse. No data is streamed, so there is no valid/ready handshake and no back-pressure: the pulses must be taken on the cycle they appear.

Top module: `credit_ledger`

## Requirements
- R1: After reset both credit digits read 0, and `coin_evt`, `start_req`, `start_two` and `test_req` are low.
- R2: Each coin, service and start input keeps a history of its three latest frame samples. It yields an event on a frame only when the oldest sample is released (1) and the two newer samples are pressed (0). A press that lasts one frame yields nothing, and a held press yields exactly one event.
- R3: Each slot has its own partial counter, and each accepted coin increments it. When the count reaches that slot's coins-per-credit value, the counter clears and the slot's credits-per-coin value is added to the balance.
- R4: The balance is two BCD digits (tens in `credit_tens`, units in `credit_ones`), each 0 to 9. An addition that takes the units digit past 9 wraps it and carries into the tens digit.
- R5: A coin or service event that arrives while the balance is 99 is dropped: no accrual and no coin event. Any addition that would pass 99 leaves the balance at 99.
- R6: Each accepted coin raises bit s of `coin_evt` for exactly the one cycle after the frame strobe. No output changes in a cycle after a non-strobe cycle.
- R7: A service event adds slot 1's credits-per-coin value. It leaves the partial counters unchanged and raises no coin event.
- R8: In the idle mode (`mode` = 0) with a nonzero balance, a start1 event subtracts 1, borrowing from the tens digit. It also pulses `start_req` and clears both partial counters.
- R9: A start2 event under the same conditions subtracts 2, and requires a balance of at least 2. It pulses `start_req` together with `start_two`. When both start events occur in one frame, start1 is taken.
- R10: Outside the idle mode, or with a zero balance, start events change nothing and raise no request.
- R11: A frame sample of test asserted (`test_n` = 0) while `mode` is not init (1) clears the balance and both partial counters, and pulses `test_req`. That frame applies no coin, service or start event. In the init mode, test is ignored.
- R12: Events of one frame apply in the order slot 0 coin, slot 1 coin, service, then start. Each step sees the balance left by the previous step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_tick | input | 1 | One-cycle strobe, once per frame |
| mode | input | 2 | Operating mode: 0 idle, 1 init, 2 active |
| coin_n | input | NUM_SLOTS | Coin switch level per slot, active low |
| service_n | input | 1 | Service switch level, active low |
| start1_n | input | 1 | One-player start level, active low |
| start2_n | input | 1 | Two-player start level, active low |
| test_n | input | 1 | Test switch level, active low |
| cfg_coins_per_credit | input | NUM_SLOTS*CNT_W | Coins needed per credit award, slot s in bits [s*CNT_W +: CNT_W] |
| cfg_credits_per_coin | input | NUM_SLOTS*4 | Credits per award, slot s in bits [s*4 +: 4] |
| credit_tens | output | 4 | Tens BCD digit of the balance |
| credit_ones | output | 4 | Units BCD digit of the balance |
| coin_evt | output | NUM_SLOTS | One-cycle pulse per accepted coin |
| start_req | output | 1 | One-cycle request to enter the active mode |
| start_two | output | 1 | Qualifies `start_req` as a two-credit start |
| test_req | output | 1 | One-cycle request to return to the init mode |

## Verification
On every cycle the assertions enforce the following properties. Both digits stay in BCD range. The outputs keep still between frame strobes. A balance of 99 blocks coin events, and start requests come only from the idle mode. Test clearing leaves zero, is never mixed with a start, and empties the partial counters. What only the bench scenarios can show is the arithmetic across frames: partial accumulation for every swept coins-per-credit and credits-per-coin pair, carry and borrow between digits, clamping at 99, the same-frame ordering, and the fact that short presses are rejected.

// File: rtl/credit_ledger_pkg.sv
package credit_ledger_pkg;

  localparam logic [1:0] MODE_IDLE   = 2'd0;
  localparam logic [1:0] MODE_INIT   = 2'd1;
  localparam logic [1:0] MODE_ACTIVE = 2'd2;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] ones;
  } bcd2_t;

  localparam bcd2_t BCD_ZERO = '{tens: 4'd0, ones: 4'd0};
  localparam bcd2_t BCD_TOP  = '{tens: 4'd9, ones: 4'd9};

  function automatic logic bcd_is_top(input bcd2_t a);
    return (a.tens == 4'd9) && (a.ones == 4'd9);
  endfunction

  function automatic logic bcd_is_zero(input bcd2_t a);
    return (a.tens == 4'd0) && (a.ones == 4'd0);
  endfunction

  // add a 0..15 amount, clamping at 99
  function automatic bcd2_t bcd_add_clamp(input bcd2_t a, input logic [3:0] amt);
    logic [4:0] u;
    logic [4:0] t;
    bcd2_t      r;
    u = 5'(a.ones) + 5'(amt);
    t = 5'(a.tens);
    if (u >= 5'd20) begin
      u = u - 5'd20;
      t = t + 5'd2;
    end else if (u >= 5'd10) begin
      u = u - 5'd10;
      t = t + 5'd1;
    end
    if (t > 5'd9) begin
      r = BCD_TOP;
    end else begin
      r.tens = t[3:0];
      r.ones = u[3:0];
    end
    return r;
  endfunction

  // subtract a small amount; caller guarantees a >= amt
  function automatic bcd2_t bcd_sub(input bcd2_t a, input logic [3:0] amt);
    bcd2_t r;
    if (a.ones >= amt) begin
      r.ones = a.ones - amt;
      r.tens = a.tens;
    end else begin
      r.ones = a.ones + 4'd10 - amt;
      r.tens = a.tens - 4'd1;
    end
    return r;
  endfunction

endpackage

// File: rtl/credit_edge_qual.sv
module credit_edge_qual #(
  parameter int NUM_IN = 5,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [NUM_IN-1:0] level_n,
  output logic [NUM_IN-1:0] evt
);

  localparam int NEWER = DEPTH - 1;

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chan
    logic [DEPTH-1:0] hist_q;
    logic [DEPTH-1:0] hist_d;

    // index 0 holds the newest sample
    assign hist_d = {hist_q[DEPTH-2:0], level_n[i]};
    assign evt[i] = tick & hist_d[DEPTH-1] & ~(|hist_d[NEWER-1:0]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hist_q <= '1;
      end else if (tick) begin
        hist_q <= hist_d;
      end
    end

    // R2: an event requires the current sample to be pressed
    p_evt_pressed_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |-> (tick && !level_n[i]));
    // R2: no event twice on consecutive strobes
    p_no_repeat_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> !evt[i]);
  end

endmodule

// File: rtl/credit_slot.sv
module credit_slot #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             coin_hit,
  input  logic             allow,
  input  logic             clear,
  input  logic [CNT_W-1:0] coins_per_credit,
  output logic             accepted,
  output logic             earn
);

  logic [CNT_W-1:0] part_q;
  logic [CNT_W-1:0] part_inc;

  assign part_inc = part_q + CNT_W'(1);
  assign accepted = coin_hit & allow;
  assign earn     = accepted & (part_inc == coins_per_credit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      part_q <= '0;
    end else if (clear) begin
      part_q <= '0;
    end else if (accepted) begin
      part_q <= earn ? '0 : part_inc;
    end
  end

  // R8 R11: a clear request empties the partial count
  p_part_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (part_q == '0));
  // R3: without an accepted coin the partial count holds unless cleared
  p_part_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accepted && !clear) |=> $stable(part_q));

endmodule

// File: rtl/credit_ledger.sv
module credit_ledger
  import credit_ledger_pkg::*;
#(
  parameter int NUM_SLOTS    = 2,
  parameter int CNT_W        = 4,
  parameter int HIST_DEPTH   = 3,
  parameter int SERVICE_SLOT = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_tick,
  input  logic [1:0]                 mode,
  input  logic [NUM_SLOTS-1:0]       coin_n,
  input  logic                       service_n,
  input  logic                       start1_n,
  input  logic                       start2_n,
  input  logic                       test_n,
  input  logic [NUM_SLOTS*CNT_W-1:0] cfg_coins_per_credit,
  input  logic [NUM_SLOTS*4-1:0]     cfg_credits_per_coin,
  output logic [3:0]                 credit_tens,
  output logic [3:0]                 credit_ones,
  output logic [NUM_SLOTS-1:0]       coin_evt,
  output logic                       start_req,
  output logic                       start_two,
  output logic                       test_req
);

  localparam int NUM_IN  = NUM_SLOTS + 3;
  localparam int IDX_SVC = NUM_SLOTS;
  localparam int IDX_ST1 = NUM_SLOTS + 1;
  localparam int IDX_ST2 = NUM_SLOTS + 2;

  bcd2_t              bal_q;
  bcd2_t              bal_d;
  bcd2_t              chain [NUM_SLOTS+1];
  bcd2_t              after_svc;
  logic [NUM_IN-1:0]  hit;
  logic [NUM_SLOTS-1:0] accepted;
  logic [NUM_SLOTS-1:0] earn;
  logic               test_hit;
  logic               svc_take;
  logic               take1;
  logic               take2;
  logic               clear_parts;
  logic               idle_mode;

  credit_edge_qual #(
    .NUM_IN (NUM_IN),
    .DEPTH  (HIST_DEPTH)
  ) u_qual (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (frame_tick),
    .level_n ({start2_n, start1_n, service_n, coin_n}),
    .evt     (hit)
  );

  assign test_hit  = frame_tick & ~test_n & (mode != MODE_INIT);
  assign idle_mode = (mode == MODE_IDLE);
  assign chain[0]  = bal_q;

  // coins apply in slot order, each on the balance the previous slot left
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic allow;
    assign allow = ~test_hit & ~bcd_is_top(chain[s]);

    credit_slot #(
      .CNT_W (CNT_W)
    ) u_slot (
      .clk              (clk),
      .rst_n            (rst_n),
      .coin_hit         (hit[s]),
      .allow            (allow),
      .clear            (clear_parts),
      .coins_per_credit (cfg_coins_per_credit[s*CNT_W +: CNT_W]),
      .accepted         (accepted[s]),
      .earn             (earn[s])
    );

    assign chain[s+1] = earn[s]
      ? bcd_add_clamp(chain[s], cfg_credits_per_coin[s*4 +: 4])
      : chain[s];
  end

  assign svc_take  = hit[IDX_SVC] & ~test_hit & ~bcd_is_top(chain[NUM_SLOTS]);
  assign after_svc = svc_take
    ? bcd_add_clamp(chain[NUM_SLOTS], cfg_credits_per_coin[SERVICE_SLOT*4 +: 4])
    : chain[NUM_SLOTS];

  assign take1 = hit[IDX_ST1] & ~test_hit & idle_mode & ~bcd_is_zero(after_svc);
  assign take2 = hit[IDX_ST2] & ~hit[IDX_ST1] & ~test_hit & idle_mode
               & ((after_svc.tens != 4'd0) || (after_svc.ones >= 4'd2));
  assign clear_parts = test_hit | take1 | take2;

  always_comb begin
    if (test_hit)   bal_d = BCD_ZERO;
    else if (take1) bal_d = bcd_sub(after_svc, 4'd1);
    else if (take2) bal_d = bcd_sub(after_svc, 4'd2);
    else            bal_d = after_svc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bal_q     <= BCD_ZERO;
      coin_evt  <= '0;
      start_req <= 1'b0;
      start_two <= 1'b0;
      test_req  <= 1'b0;
    end else begin
      if (frame_tick) bal_q <= bal_d;
      coin_evt  <= accepted;
      start_req <= take1 | take2;
      start_two <= take2;
      test_req  <= test_hit;
    end
  end

  assign credit_tens = bal_q.tens;
  assign credit_ones = bal_q.ones;

  // R4: both digits stay in decimal range
  p_bcd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (credit_tens <= 4'd9) && (credit_ones <= 4'd9));
  // R6: nothing moves after a cycle without a frame strobe
  p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> ((coin_evt == '0) && !start_req && !test_req
                     && $stable(credit_tens) && $stable(credit_ones)));
  // R5: a full balance accepts no coin
  p_full_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && credit_tens == 4'd9 && credit_ones == 4'd9) |=> (coin_evt == '0));
  // R10: starts are granted only from idle
  p_start_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && mode != MODE_IDLE) |=> !start_req);
  // R11: a test clear leaves an empty balance and no start
  p_test_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    test_req |-> (credit_tens == 4'd0 && credit_ones == 4'd0 && !start_req));
  // R9: the two-credit flag never appears alone
  p_two_with_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_two |-> start_req);

endmodule

// File: tb/credit_ledger_tb.sv
module credit_ledger_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic [1:0] mode = 2'd2;
  logic [1:0] coin_n = 2'b11;
  logic       service_n = 1'b1;
  logic       start1_n = 1'b1;
  logic       start2_n = 1'b1;
  logic       test_n = 1'b1;
  logic [7:0] cfg_coins_per_credit;
  logic [7:0] cfg_credits_per_coin;
  logic [3:0] credit_tens, credit_ones;
  logic [1:0] coin_evt;
  logic       start_req, start_two, test_req;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state
  logic [2:0] hh [5];
  int cred;
  int part [2];
  int cpc [2];
  int crpc [2];

  always #5 clk = ~clk;

  assign cfg_coins_per_credit = {4'(cpc[1]), 4'(cpc[0])};
  assign cfg_credits_per_coin = {4'(crpc[1]), 4'(crpc[0])};

  credit_ledger u_dut (
    .clk (clk), .rst_n (rst_n), .frame_tick (frame_tick), .mode (mode),
    .coin_n (coin_n), .service_n (service_n), .start1_n (start1_n),
    .start2_n (start2_n), .test_n (test_n),
    .cfg_coins_per_credit (cfg_coins_per_credit),
    .cfg_credits_per_coin (cfg_credits_per_coin),
    .credit_tens (credit_tens), .credit_ones (credit_ones),
    .coin_evt (coin_evt), .start_req (start_req), .start_two (start_two),
    .test_req (test_req)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_bal(input string req);
    int act;
    act = int'(credit_tens) * 10 + int'(credit_ones);
    chk(credit_tens <= 9 && credit_ones <= 9 && act == cred, req, act, cred);
  endtask

  // one frame; pm bits: 0 coin0, 1 coin1, 2 service, 3 start1, 4 start2 (1 = pressed)
  task automatic frame(input logic [4:0] pm, input bit tst);
    logic [4:0] lv;
    logic [4:0] ev;
    logic [1:0] e_coin;
    bit e_st, e_two, e_test;
    lv = ~pm;
    e_coin = 2'b00; e_st = 0; e_two = 0; e_test = 0;
    for (int i = 0; i < 5; i++) begin
      hh[i] = {hh[i][1:0], lv[i]};
      ev[i] = (hh[i] == 3'b100);  // R2 history rule
    end
    @(negedge clk);
    coin_n = lv[1:0]; service_n = lv[2]; start1_n = lv[3]; start2_n = lv[4];
    test_n = ~tst; frame_tick = 1'b1;
    if (tst && mode != 2'd1) begin  // R11
      cred = 0; part[0] = 0; part[1] = 0; e_test = 1;
    end else begin
      for (int s = 0; s < 2; s++) begin  // R12 order, R3, R5
        if (ev[s] && cred < 99) begin
          e_coin[s] = 1'b1;
          part[s]++;
          if (part[s] == cpc[s]) begin
            part[s] = 0;
            cred = (cred + crpc[s] > 99) ? 99 : cred + crpc[s];
          end
        end
      end
      if (ev[2] && cred < 99) cred = (cred + crpc[1] > 99) ? 99 : cred + crpc[1];  // R7
      if (mode == 2'd0 && cred > 0) begin  // R8 R9 R10
        if (ev[3]) begin cred -= 1; e_st = 1; end
        else if (ev[4] && cred >= 2) begin cred -= 2; e_st = 1; e_two = 1; end
        if (e_st) begin part[0] = 0; part[1] = 0; end
      end
    end
    @(negedge clk);
    frame_tick = 1'b0;
    chk_bal("R4");
    chk(coin_evt == e_coin, "R6", int'(coin_evt), int'(e_coin));
    chk(start_req == e_st, "R8", int'(start_req), int'(e_st));
    chk(start_two == e_two, "R9", int'(start_two), int'(e_two));
    chk(test_req == e_test, "R11", int'(test_req), int'(e_test));
    @(negedge clk);
    chk(coin_evt == 2'b00 && !start_req && !test_req, "R6", int'(coin_evt), 0);
    chk_bal("R6");
  endtask

  task automatic press(input logic [4:0] pm);
    frame(5'b0, 0);
    frame(pm, 0);
    frame(pm, 0);
  endtask

  task automatic wipe();
    mode = 2'd2;
    frame(5'b0, 1);
    frame(5'b0, 0);
  endtask

  initial begin
    for (int i = 0; i < 5; i++) hh[i] = 3'b111;
    cred = 0; part[0] = 0; part[1] = 0;
    cpc[0] = 1; cpc[1] = 1; crpc[0] = 1; crpc[1] = 1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(credit_tens == 0 && credit_ones == 0, "R1", int'(credit_ones), 0);
    chk(coin_evt == 0 && !start_req && !start_two && !test_req, "R1", int'(coin_evt), 0);

    // R3 R4 sweep slot 0
    for (int c = 1; c <= 3; c++) begin
      for (int r = 1; r <= 9; r++) begin
        wipe();
        cpc[0] = c; crpc[0] = r;
        for (int k = 0; k < 2 * c + 1; k++) press(5'b00001);
        chk_bal("R3");
        chk(cred == ((2 * c + 1) / c) * r, "R3", cred, ((2 * c + 1) / c) * r);
      end
    end
    // R3 sweep slot 1, slot 0 partial independent
    for (int c = 1; c <= 4; c++) begin
      wipe();
      cpc[0] = 3; crpc[0] = 1; cpc[1] = c; crpc[1] = 2;
      press(5'b00001);
      for (int k = 0; k < c; k++) press(5'b00010);
      chk(cred == 2, "R3", cred, 2);
    end

    // R2 one-frame press and long hold
    wipe();
    cpc[0] = 1; crpc[0] = 1;
    frame(5'b0, 0); frame(5'b00001, 0); frame(5'b0, 0); frame(5'b0, 0);
    chk(cred == 0, "R2", cred, 0);
    frame(5'b00001, 0); frame(5'b00001, 0); frame(5'b00001, 0); frame(5'b00001, 0);
    chk(cred == 1, "R2", cred, 1);

    // R5 saturation
    wipe();
    cpc[0] = 1; crpc[0] = 9; cpc[1] = 1; crpc[1] = 7;
    for (int k = 0; k < 12; k++) press(5'b00001);
    chk(cred == 99, "R5", cred, 99);
    press(5'b00011);
    press(5'b00100);
    chk(cred == 99, "R5", cred, 99);

    // R7 service, R12 same-frame order
    wipe();
    cpc[0] = 2; crpc[0] = 3; cpc[1] = 1; crpc[1] = 4;
    press(5'b00100);
    press(5'b00001);
    chk(cred == 4, "R7", cred, 4);
    press(5'b00111);
    chk(cred == 15, "R12", cred, 15);

    // R8 R9 R10 starts
    mode = 2'd2;
    press(5'b01000);
    chk(cred == 15, "R10", cred, 15);
    mode = 2'd0;
    press(5'b01000);
    chk(cred == 14, "R8", cred, 14);
    press(5'b10000);
    press(5'b11000);
    chk(cred == 11, "R9", cred, 11);
    press(5'b01000);
    chk(cred == 10, "R8", cred, 10);
    press(5'b01000);
    chk(cred == 9, "R8", cred, 9);
    // R8 partial clear after start
    wipe();
    mode = 2'd0; cpc[0] = 3; crpc[0] = 2;
    for (int k = 0; k < 3; k++) press(5'b00001);
    press(5'b00001); press(5'b00001);
    press(5'b01000);
    press(5'b00001); press(5'b00001);
    chk(cred == 1, "R8", cred, 1);
    press(5'b10000);
    chk(cred == 1, "R9", cred, 1);
    press(5'b00001);
    chk(cred == 3, "R8", cred, 3);
    // R10 zero balance
    wipe();
    mode = 2'd0;
    press(5'b01000);
    chk(cred == 0, "R10", cred, 0);

    // R11 test ignored in init, effective otherwise
    cpc[0] = 1; crpc[0] = 5;
    press(5'b00001);
    mode = 2'd1;
    frame(5'b0, 1);
    chk(cred == 5, "R11", cred, 5);
    mode = 2'd0;
    frame(5'b0, 1);
    chk(cred == 0, "R11", cred, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule